// File: doc/BRIEF.md
# Constant-Weight Product Select Sequencer

This block picks out product lines of a programmable logic array one at a time. It drives a small set of extra decoder lines in the array's AND plane. On every step it applies one constant-weight codeword to those lines. A codeword has exactly M lines high out of N, and it selects one product of every output at the same moment. After a programmable settle time, the block samples the two spare reference outputs. The first spare carries the selected product of the true output. The second carries the selected product of the complement output. The sampled values go into one bitmap per spare, indexed by codeword number.

The block has two scan modes. The activity scan marks products whose reference reads high, which locates the active products after an AND-plane deletion has been detected. The decoder self-test raises a force line that holds every primary input of the array at 1 for the whole scan. It then marks a product as faulty when its reference reads low. Each bitmap is bounded by the product count given for its own output. The number of codewords applied is the larger of the two counts. When the scan ends, the block gives a one-cycle done pulse and holds both bitmaps until the next start.

Top module: `mofn_select_seq`

## Requirements
- R1: After reset, dec_code_o is all zero, and dec_valid_o, pin_force_o, busy_o and done_o are 0. Both bitmaps are all zero.
- R2: While dec_valid_o is 1, dec_code_o has exactly DEC_ONES bits set. While dec_valid_o is 0, dec_code_o is all zero.
- R3: The codewords of a scan are all the DEC_LINES-bit values with DEC_ONES ones, taken in ascending numeric order. The first is the value with the DEC_ONES lowest bits set. Codeword k (counting from 0) selects product k of both outputs.
- R4: A scan applies min(max(nprod_t_i, nprod_c_i), MAX_PROD, C(DEC_LINES, DEC_ONES)) codewords. If this number is zero, no codeword is applied and done_o pulses in the cycle after the start is taken.
- R5: Each codeword is held for S cycles, where S is the captured settle_i value and a value of 0 counts as 1. The references are sampled at the clock edge that ends the S-th cycle of the codeword.
- R6: In the activity scan (scan_mode_i = 0), map_t_o bit k is 1 exactly when ref_t_i was high at the sample of codeword k and k < nprod_t_i. map_c_o follows the same rule with ref_c_i and nprod_c_i.
- R7: In the decoder self-test (scan_mode_i = 1), map_t_o bit k is 1 exactly when ref_t_i was low at the sample of codeword k and k < nprod_t_i. map_c_o follows the same rule with ref_c_i and nprod_c_i. Bits at or above the applied codeword count stay 0 in both modes.
- R8: pin_force_o is 1 in every cycle that a codeword is applied during a self-test scan. It is 0 during an activity scan and while no scan runs.
- R9: done_o is 1 for exactly one cycle, right after the last sample. From then until the next accepted start, both bitmaps are stable.
- R10: A start is accepted only while the block is idle. A start that arrives during a scan or during the done cycle is ignored.
- R11: The mode, settle value and both product counts are captured when a start is accepted. Later changes to these inputs do not affect the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| scan_mode_i | input | 1 | 0 = activity scan, 1 = decoder self-test |
| settle_i | input | SET_W | Cycles each codeword is held before sampling (0 counts as 1) |
| nprod_t_i | input | CNT_W | Product count of the true output |
| nprod_c_i | input | CNT_W | Product count of the complement output |
| ref_t_i | input | 1 | Spare reference output wired to the true function |
| ref_c_i | input | 1 | Spare reference output wired to the complement function |
| dec_code_o | output | DEC_LINES | Codeword driven onto the decoder lines |
| dec_valid_o | output | 1 | A codeword is being applied |
| pin_force_o | output | 1 | Hold all primary inputs at 1 (self-test) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| map_t_o | output | MAX_PROD | Per-product result for the true output |
| map_c_o | output | MAX_PROD | Per-product result for the complement output |

## Verification
The hardest thing to show from the ports is that a reference is sampled at the right edge and not one cycle early. The bench models the array so that each reference returns the inverse of its true value until the codeword has been held for the settle count. A sample taken even one edge early therefore flips bits in the bitmap. The upper clamp is also hard to reach, because the codeword supply runs out before the bitmap width does. A scan with a product count equal to the full bitmap width forces the codeword table to run dry. That scan checks the full ascending order of the codewords and checks that the top bitmap bits stay clear.

// File: rtl/mofn_seq_pkg.sv
package mofn_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_APPLY = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  // number of n-bit words with exactly k ones
  function automatic int unsigned binom(input int unsigned n, input int unsigned k);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < k; i++) begin
      r = r * (n - i) / (i + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/mofn_code_gen.sv
module mofn_code_gen #(
  parameter int unsigned N = 6,
  parameter int unsigned M = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  output logic [N-1:0] code_o
);

  localparam logic [N-1:0] FIRST_CODE = N'((64'd1 << M) - 64'd1);

  // next larger word with the same number of ones
  function automatic logic [N-1:0] next_code(input logic [N-1:0] c);
    logic [N-1:0] r;
    int p;
    int q;
    logic fp;
    logic fq;
    p  = 0;
    q  = N;
    fp = 1'b0;
    fq = 1'b0;
    for (int b = 0; b < N; b++) begin
      if (!fp && c[b]) begin
        p  = b;
        fp = 1'b1;
      end else if (fp && !fq && !c[b]) begin
        q  = b;
        fq = 1'b1;
      end
    end
    r = '0;
    for (int b = 0; b < N; b++) begin
      if (b > q)               r[b] = c[b];
      else if (b == q)         r[b] = 1'b1;
      else if (b < q - p - 1)  r[b] = 1'b1;
    end
    return r;
  endfunction

  logic [N-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= FIRST_CODE;
    else if (load_i) code_q <= FIRST_CODE;
    else if (step_i) code_q <= next_code(code_q);
  end

  assign code_o = code_q;

  // R3
  code_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (code_o > $past(code_o)));

endmodule

// File: rtl/mofn_settle_timer.sv
module mofn_settle_timer #(
  parameter int unsigned SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SET_W-1:0] val_i,
  input  logic             run_i,
  output logic             expire_o
);

  function automatic logic [SET_W-1:0] eff_settle(input logic [SET_W-1:0] v);
    return (v == '0) ? SET_W'(1) : v;
  endfunction

  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= SET_W'(1);
    else if (load_i)                    cnt_q <= eff_settle(val_i);
    else if (run_i && cnt_q != SET_W'(1)) cnt_q <= cnt_q - SET_W'(1);
  end

  assign expire_o = run_i && (cnt_q == SET_W'(1));

  // R5
  settle_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q != '0));

endmodule

// File: rtl/mofn_prod_bitmap.sv
module mofn_prod_bitmap #(
  parameter int unsigned P     = 24,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             mode_i,
  input  logic             ref_i,
  output logic [P-1:0]     map_o
);

  // activity scan marks high references, self-test marks low ones
  function automatic logic flag_of(input logic mode, input logic r);
    return mode ? ~r : r;
  endfunction

  logic [P-1:0] map_q;

  for (genvar b = 0; b < P; b++) begin : g_bit
    logic hit;
    assign hit = cap_i && (idx_i == CNT_W'(b)) && (CNT_W'(b) < cnt_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     map_q[b] <= 1'b0;
      else if (clr_i) map_q[b] <= 1'b0;
      else if (hit)   map_q[b] <= flag_of(mode_i, ref_i);
    end
  end

  assign map_o = map_q;

  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cap_i) |=> $stable(map_o));

endmodule

// File: rtl/mofn_select_seq.sv
module mofn_select_seq
  import mofn_seq_pkg::*;
#(
  parameter int unsigned DEC_LINES = 6,
  parameter int unsigned DEC_ONES  = DEC_LINES / 2,
  parameter int unsigned MAX_PROD  = 24,
  parameter int unsigned SET_W     = 4,
  localparam int unsigned CNT_W    = $clog2(MAX_PROD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 scan_mode_i,
  input  logic [SET_W-1:0]     settle_i,
  input  logic [CNT_W-1:0]     nprod_t_i,
  input  logic [CNT_W-1:0]     nprod_c_i,
  input  logic                 ref_t_i,
  input  logic                 ref_c_i,
  output logic [DEC_LINES-1:0] dec_code_o,
  output logic                 dec_valid_o,
  output logic                 pin_force_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [MAX_PROD-1:0]  map_t_o,
  output logic [MAX_PROD-1:0]  map_c_o
);

  localparam int unsigned NUM_CODES = binom(DEC_LINES, DEC_ONES);

  // codewords applied: larger count, clipped by bitmap width and code supply
  function automatic logic [CNT_W-1:0] scan_len(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
    int unsigned r;
    r = (a > b) ? 32'(a) : 32'(b);
    if (r > MAX_PROD)  r = MAX_PROD;
    if (r > NUM_CODES) r = NUM_CODES;
    return CNT_W'(r);
  endfunction

  seq_state_e       state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_t_q;
  logic [CNT_W-1:0] cnt_c_q;
  logic [SET_W-1:0] settle_q;
  logic             mode_q;

  logic             start_acc;
  logic             sample_evt;
  logic             last_code;
  logic             applying;
  logic [CNT_W-1:0] len_new;
  logic [DEC_LINES-1:0] gen_code;

  assign applying   = (state_q == ST_APPLY);
  assign start_acc  = start_i && (state_q == ST_IDLE);
  assign len_new    = scan_len(nprod_t_i, nprod_c_i);
  assign last_code  = (idx_q == len_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      cnt_t_q  <= '0;
      cnt_c_q  <= '0;
      settle_q <= '0;
      mode_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            mode_q   <= scan_mode_i;
            settle_q <= settle_i;
            cnt_t_q  <= nprod_t_i;
            cnt_c_q  <= nprod_c_i;
            len_q    <= len_new;
            idx_q    <= '0;
            state_q  <= (len_new == '0) ? ST_DONE : ST_APPLY;
          end
        end
        ST_APPLY: begin
          if (sample_evt) begin
            if (last_code) state_q <= ST_DONE;
            else           idx_q   <= idx_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mofn_code_gen #(.N(DEC_LINES), .M(DEC_ONES)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_acc),
    .step_i (sample_evt && !last_code),
    .code_o (gen_code)
  );

  mofn_settle_timer #(.SET_W(SET_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_acc || (sample_evt && !last_code)),
    .val_i    (start_acc ? settle_i : settle_q),
    .run_i    (applying),
    .expire_o (sample_evt)
  );

  mofn_prod_bitmap #(.P(MAX_PROD), .CNT_W(CNT_W)) u_map_t (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_acc),
    .cap_i  (sample_evt),
    .idx_i  (idx_q),
    .cnt_i  (cnt_t_q),
    .mode_i (mode_q),
    .ref_i  (ref_t_i),
    .map_o  (map_t_o)
  );

  mofn_prod_bitmap #(.P(MAX_PROD), .CNT_W(CNT_W)) u_map_c (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_acc),
    .cap_i  (sample_evt),
    .idx_i  (idx_q),
    .cnt_i  (cnt_c_q),
    .mode_i (mode_q),
    .ref_i  (ref_c_i),
    .map_o  (map_c_o)
  );

  assign dec_valid_o = applying;
  assign dec_code_o  = applying ? gen_code : '0;
  assign pin_force_o = applying && mode_q;
  assign busy_o      = applying;
  assign done_o      = (state_q == ST_DONE);

  // R2
  code_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> ($countones(dec_code_o) == DEC_ONES));

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q < len_q));

  // R8
  force_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(pin_force_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sample_evt) |=> ($stable(idx_q) && $stable(len_q) && busy_o));

endmodule

// File: tb/tb_mofn_select_seq.sv
`timescale 1ns/1ps
module tb_mofn_select_seq;

  localparam int N     = 6;
  localparam int M     = 3;
  localparam int P     = 24;
  localparam int SW    = 4;
  localparam int CW    = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          scan_mode_i = 1'b0;
  logic [SW-1:0] settle_i = '0;
  logic [CW-1:0] nprod_t_i = '0;
  logic [CW-1:0] nprod_c_i = '0;
  logic          ref_t_i = 1'b0;
  logic          ref_c_i = 1'b0;
  logic [N-1:0]  dec_code_o;
  logic          dec_valid_o, pin_force_o, busy_o, done_o;
  logic [P-1:0]  map_t_o, map_c_o;

  always #2.5 clk = ~clk;

  mofn_select_seq #(.DEC_LINES(N), .DEC_ONES(M), .MAX_PROD(P), .SET_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_mode_i(scan_mode_i),
    .settle_i(settle_i), .nprod_t_i(nprod_t_i), .nprod_c_i(nprod_c_i),
    .ref_t_i(ref_t_i), .ref_c_i(ref_c_i), .dec_code_o(dec_code_o),
    .dec_valid_o(dec_valid_o), .pin_force_o(pin_force_o), .busy_o(busy_o),
    .done_o(done_o), .map_t_o(map_t_o), .map_c_o(map_c_o)
  );

  int chk_cnt = 0;
  int fail_cnt = 0;

  // expected codeword list, built by enumeration
  logic [N-1:0] exp_code [0:63];
  int num_codes = 0;

  // array model state
  logic [P-1:0] pat_t = '0;
  logic [P-1:0] pat_c = '0;
  int lat = 1;
  int age = 0;
  logic [N-1:0] prev_code = '0;
  logic prev_vld = 1'b0;

  // monitor records
  logic [N-1:0] seen_code [0:31];
  int hold_cnt [0:31];
  int n_seen = 0;
  int done_cycles = 0;
  int force_bad = 0;
  int idle_bad = 0;
  logic exp_force = 1'b0;

  function automatic int rank_of(input logic [N-1:0] c);
    for (int k = 0; k < num_codes; k++) if (exp_code[k] == c) return k;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (dec_valid_o) begin
      if (!prev_vld || dec_code_o != prev_code) begin
        age = 1;
        if (n_seen < 32) begin
          seen_code[n_seen] = dec_code_o;
          hold_cnt[n_seen] = 1;
          n_seen++;
        end
      end else begin
        age++;
        if (n_seen > 0 && n_seen <= 32) hold_cnt[n_seen-1]++;
      end
      if (pin_force_o !== exp_force) force_bad++;
      ref_t_i <= (age >= lat) ? pat_t[rank_of(dec_code_o)] : ~pat_t[rank_of(dec_code_o)];
      ref_c_i <= (age >= lat) ? pat_c[rank_of(dec_code_o)] : ~pat_c[rank_of(dec_code_o)];
    end else begin
      if (dec_code_o != '0 || pin_force_o) idle_bad++;
      ref_t_i <= 1'b0;
      ref_c_i <= 1'b0;
    end
    if (done_o) done_cycles++;
    prev_code = dec_code_o;
    prev_vld  = dec_valid_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int ct, input int cc);
    int r;
    r = (ct > cc) ? ct : cc;
    if (r > P) r = P;
    if (r > num_codes) r = num_codes;
    return r;
  endfunction

  function automatic logic [P-1:0] exp_map(input logic [P-1:0] pat, input int cnt,
                                           input int len, input bit mode);
    logic [P-1:0] r;
    r = '0;
    for (int k = 0; k < P; k++)
      if (k < len && k < cnt) r[k] = mode ? ~pat[k] : pat[k];
    return r;
  endfunction

  task automatic kick(input bit mode, input int ct, input int cc, input int s);
    @(negedge clk); #1;
    n_seen = 0; done_cycles = 0; force_bad = 0; idle_bad = 0;
    exp_force = mode;
    lat = (s == 0) ? 1 : s;
    scan_mode_i = mode;
    nprod_t_i = CW'(ct);
    nprod_c_i = CW'(cc);
    settle_i = SW'(s);
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (done_cycles == 0 && t < 2000) begin
      @(negedge clk); #1;
      t++;
    end
    check(done_cycles != 0, req, "done timeout", t, 0);
    @(negedge clk); #1;
  endtask

  task automatic verify(input string tag, input bit mode, input int ct,
                        input int cc, input int s);
    int len, seff;
    bit ord_ok, hold_ok;
    len = exp_len(ct, cc);
    seff = (s == 0) ? 1 : s;
    check(n_seen == len, "R4", {tag, " codeword count"}, n_seen, len);
    ord_ok = 1; hold_ok = 1;
    for (int k = 0; k < n_seen && k < 32; k++) begin
      if (seen_code[k] != exp_code[k] || $countones(seen_code[k]) != M) ord_ok = 0;
      if (hold_cnt[k] != seff) hold_ok = 0;
    end
    check(ord_ok, "R3", {tag, " codeword order/R2 weight"}, ord_ok, 1);
    check(hold_ok, "R5", {tag, " settle hold"}, hold_ok, 1);
    check(map_t_o == exp_map(pat_t, ct, len, mode), mode ? "R7" : "R6",
          {tag, " map_t"}, map_t_o, exp_map(pat_t, ct, len, mode));
    check(map_c_o == exp_map(pat_c, cc, len, mode), mode ? "R7" : "R6",
          {tag, " map_c"}, map_c_o, exp_map(pat_c, cc, len, mode));
    check(force_bad == 0 && idle_bad == 0, "R8", {tag, " force/idle code"},
          force_bad + idle_bad, 0);
    check(done_cycles == 1, "R9", {tag, " done width"}, done_cycles, 1);
  endtask

  task automatic t_reset;
    check(dec_code_o == '0 && !dec_valid_o && !pin_force_o && !busy_o && !done_o,
          "R1", "outputs in reset", {dec_code_o, dec_valid_o, pin_force_o, busy_o, done_o}, 0);
    check(map_t_o == '0 && map_c_o == '0, "R1", "maps in reset", map_t_o | map_c_o, 0);
  endtask

  task automatic t_activity_a;   // R6
    pat_t = 24'h00001A; pat_c = 24'h000005;
    kick(0, 5, 3, 3); wait_done("R6"); verify("act_a", 0, 5, 3, 3);
  endtask

  task automatic t_activity_b;   // R6
    pat_t = 24'h000003; pat_c = 24'h000055;
    kick(0, 2, 7, 1); wait_done("R6"); verify("act_b", 0, 2, 7, 1);
  endtask

  task automatic t_selftest;     // R7 R8
    pat_t = 24'h00002F; pat_c = 24'h00003B;
    kick(1, 6, 6, 2); wait_done("R7"); verify("dtest", 1, 6, 6, 2);
  endtask

  task automatic t_clamp;        // R4 R3
    pat_t = 24'hFFFFFF; pat_c = 24'h000000;
    kick(0, 24, 0, 1); wait_done("R4"); verify("clamp", 0, 24, 0, 1);
    check(map_t_o[P-1:20] == '0, "R7", "bits above code supply", map_t_o[P-1:20], 0);
  endtask

  task automatic t_zero;         // R4
    kick(0, 0, 0, 4); wait_done("R4"); verify("zero", 0, 0, 0, 4);
    check(map_t_o == '0 && map_c_o == '0, "R4", "maps cleared on zero scan",
          map_t_o | map_c_o, 0);
  endtask

  task automatic t_settle_zero;  // R5
    pat_t = 24'h000009; pat_c = 24'h000006;
    kick(1, 4, 4, 0); wait_done("R5"); verify("s0", 1, 4, 4, 0);
  endtask

  task automatic t_busy_start;   // R10 R11
    pat_t = 24'h000015; pat_c = 24'h00000A;
    kick(0, 5, 5, 2);
    repeat (3) @(negedge clk);
    #1;
    scan_mode_i = 1; nprod_t_i = CW'(1); nprod_c_i = CW'(9); settle_i = SW'(7);
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    wait_done("R10");
    verify("busy_start_R10_R11", 0, 5, 5, 2);
  endtask

  task automatic t_done_start;   // R10: start during done cycle
    logic [P-1:0] mt;
    pat_t = 24'h000003; pat_c = 24'h000001;
    kick(0, 2, 2, 1);
    while (!done_o) begin @(negedge clk); #1; end
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    mt = map_t_o;
    check(!busy_o && !dec_valid_o, "R10", "start in done cycle ignored", busy_o, 0);
    repeat (6) @(negedge clk);
    #1;
    check(map_t_o == mt && map_t_o == 24'h000003, "R9", "map held after done", map_t_o, 3);
  endtask

  initial begin
    int k;
    k = 0;
    for (int v = 0; v < (1 << N); v++)
      if ($countones(v[N-1:0]) == M && k < 64) begin
        exp_code[k] = v[N-1:0];
        k++;
      end
    num_codes = k;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_activity_a();
    t_activity_b();
    t_selftest();
    t_clamp();
    t_zero();
    t_settle_zero();
    t_busy_start();
    t_done_start();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk_cnt++;
    fail_cnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

endmodule